// File: doc/BRIEF.md
# Single-Cycle Processor Datapath

This block is the execution half of a 32-bit processor that completes one instruction per clock. It holds the program counter, a register file of 32 words and an instruction store. The instruction store is a read-only array filled from a parameter. The block also holds a data store, immediate sign extension, an arithmetic/logic unit and the next-PC selection. It decodes nothing itself. Eight control inputs, produced by an external decoder, steer its multiplexers and write enables. It hands the instruction's opcode and function fields back to that decoder.

The instruction word uses fixed fields. Bits 25:21 and 20:16 name the two source registers. Bits 15:11 name the R-form destination. Bits 15:0 hold the immediate, and bits 25:0 hold the jump index. A debug read port on the register file and outputs for the PC, the instruction and the ALU result let a system or bench watch progress.

Top module: `sc_datapath`

## Requirements
- R1: Read port A is addressed by instruction bits 25:21 and read port B by bits 20:16. Reads are combinational, and a register write lands on the rising clock edge.
- R2: The destination register is bits 20:16 when `ctl_dst_rd` is 0 and bits 15:11 when it is 1.
- R3: The immediate is bits 15:0 sign-extended to 32 bits. The second ALU operand is read port B when `ctl_alu_imm` is 0 and the immediate when it is 1.
- R4: `ctl_alu_op` selects the ALU function: 000 AND, 001 OR, 010 add, 100 A AND NOT B, 101 A OR NOT B, 110 subtract, 111 signed set-less-than (result 1 or 0). Code 011 yields 0.
- R5: With `ctl_mem_wr` at 1, read port B is stored into the data store at the ALU result address on the rising edge. With `ctl_wb_mem` at 1, the word read from that address is written back instead of the ALU result. Both stores use address bits [k+1:2].
- R6: No register changes on an edge where `ctl_reg_wr` is 0.
- R7: With `ctl_branch` at 1 and a zero ALU result, the next PC is PC+4 plus the immediate shifted left by 2. Otherwise, absent a jump, the PC advances by 4.
- R8: With `ctl_jump` at 1, the next PC takes bits 31:28 from PC+4, bits 27:2 from instruction bits 25:0, and zeros in bits 1:0.
- R9: An active-low `rst_n` clears the PC and every register to 0 at once.
- R10: `op_field` shows instruction bits 31:26 and `fn_field` shows bits 5:0.
- R11: Register 0 always reads as 0, and writes to it are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_reg_wr | input | 1 | Enable the register write-back |
| ctl_dst_rd | input | 1 | Destination from bits 15:11 instead of 20:16 |
| ctl_alu_imm | input | 1 | Second ALU operand is the immediate |
| ctl_branch | input | 1 | Conditional branch on ALU zero |
| ctl_mem_wr | input | 1 | Write the data store |
| ctl_wb_mem | input | 1 | Write back the data store word |
| ctl_jump | input | 1 | Take the jump target |
| ctl_alu_op | input | 3 | ALU function code |
| op_field | output | 6 | Instruction bits 31:26 |
| fn_field | output | 6 | Instruction bits 5:0 |
| dbg_pc | output | 32 | Current PC |
| dbg_instr | output | 32 | Current instruction word |
| dbg_alu_y | output | 32 | ALU result |
| dbg_reg_sel | input | 5 | Debug register read address |
| dbg_reg_val | output | 32 | Debug register read data |

## Verification
The bench runs a short program and plays the external decoder from a vector table. Three corner cases get their own vectors:
- A store followed by a load catches a data store indexed by the wrong address bits: the load would return the wrong word.
- A forward branch, a backward branch with a negative immediate, and a jump catch offsets that are unshifted or zero-extended: the PC would land at the wrong address.
- An R-form result sent to the rt field while `ctl_dst_rd` is low catches an inverted destination select: the value would appear in the rd register.

Writes aimed at register 0, and a write-class instruction with the write enable low, must leave the visible register values unchanged.

// File: rtl/sc_pkg.sv
package sc_pkg;
   localparam int XLEN   = 32;
   localparam int RA_W   = 5;
   localparam int NREG   = 1 << RA_W;
   localparam int IMM_W  = 16;
   localparam int JIDX_W = 26;

   typedef enum logic [2:0] {
      ALU_AND  = 3'b000,
      ALU_OR   = 3'b001,
      ALU_ADD  = 3'b010,
      ALU_NONE = 3'b011,
      ALU_ANDN = 3'b100,
      ALU_ORN  = 3'b101,
      ALU_SUB  = 3'b110,
      ALU_SLT  = 3'b111
   } alu_op_e;

   function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
      return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
   endfunction
endpackage

// File: rtl/sc_alu.sv
module sc_alu
   import sc_pkg::*;
(
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  logic [2:0]      op,
   output logic [XLEN-1:0] y,
   output logic            zero
);
   always_comb begin
      unique case (alu_op_e'(op))
         ALU_AND:  y = a & b;
         ALU_OR:   y = a | b;
         ALU_ADD:  y = a + b;
         ALU_ANDN: y = a & ~b;
         ALU_ORN:  y = a | ~b;
         ALU_SUB:  y = a - b;
         ALU_SLT:  y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
         default:  y = '0;
      endcase
   end
   assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
   import sc_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [RA_W-1:0] waddr,
   input  logic [XLEN-1:0] wdata,
   input  logic [RA_W-1:0] raddr_a,
   input  logic [RA_W-1:0] raddr_b,
   input  logic [RA_W-1:0] raddr_d,
   output logic [XLEN-1:0] rdata_a,
   output logic [XLEN-1:0] rdata_b,
   output logic [XLEN-1:0] rdata_d
);
   logic [XLEN-1:0] regs [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      if (g == 0) begin : g_zero
         assign regs[g] = '0;
      end else begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               regs[g] <= '0;
            else if (we && waddr == RA_W'(g))
               regs[g] <= wdata;
         end
      end
   end

   assign rdata_a = regs[raddr_a];
   assign rdata_b = regs[raddr_b];
   assign rdata_d = regs[raddr_d];

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr != '0) |=> regs[$past(waddr)] == $past(wdata)); // R1
   AST_ZERO_REG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr == '0) |=> rdata_d == '0 || raddr_d != '0); // R11
   AST_NO_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!we && raddr_d == $past(raddr_d)) |=> rdata_d == $past(rdata_d)); // R6
endmodule

// File: rtl/sc_word_mem.sv
module sc_word_mem
   import sc_pkg::*;
#(
   parameter int WORDS    = 32,
   parameter bit WRITABLE = 1'b1,
   parameter logic [WORDS*XLEN-1:0] INIT = '0
) (
   input  logic            clk,
   input  logic            we,
   input  logic [XLEN-1:0] addr,
   input  logic [XLEN-1:0] wdata,
   output logic [XLEN-1:0] rdata
);
   localparam int IDX_W = $clog2(WORDS);

   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0 || IDX_W + 2 > XLEN) begin : g_bad
      $error("sc_word_mem: WORDS must be a power of two within the address range");
   end

   logic [IDX_W-1:0] idx;
   assign idx = addr[IDX_W+1:2];

   logic unused_mem_in;

   if (WRITABLE) begin : g_ram
      logic [XLEN-1:0] mem [WORDS];
      always_ff @(posedge clk) begin
         if (we)
            mem[idx] <= wdata;
      end
      assign rdata = mem[idx];
      assign unused_mem_in = ^{addr[XLEN-1:IDX_W+2], addr[1:0]};

      AST_STORE_LANDS: assert property (@(posedge clk)
         we |=> mem[$past(idx)] == $past(wdata)); // R5
   end else begin : g_rom
      assign rdata = INIT[idx*XLEN +: XLEN];
      assign unused_mem_in = ^{we, wdata, addr[XLEN-1:IDX_W+2], addr[1:0], clk};
   end
endmodule

// File: rtl/sc_next_pc.sv
module sc_next_pc
   import sc_pkg::*;
(
   input  logic [XLEN-1:0]   pc,
   input  logic [XLEN-1:0]   imm_ext,
   input  logic [JIDX_W-1:0] jidx,
   input  logic              branch,
   input  logic              zero,
   input  logic              jump,
   output logic [XLEN-1:0]   pc_next
);
   logic [XLEN-1:0] pc_inc, br_tgt, j_tgt;

   assign pc_inc = pc + XLEN'(4);
   assign br_tgt = pc_inc + {imm_ext[XLEN-3:0], 2'b00};
   assign j_tgt  = {pc_inc[XLEN-1:JIDX_W+2], jidx, 2'b00};

   always_comb begin
      if (jump)
         pc_next = j_tgt;
      else if (branch && zero)
         pc_next = br_tgt;
      else
         pc_next = pc_inc;
   end
endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
   import sc_pkg::*;
#(
   parameter int IMEM_WORDS = 32,
   parameter int DMEM_WORDS = 32,
   parameter logic [IMEM_WORDS*XLEN-1:0] IMEM_INIT = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ctl_reg_wr,
   input  logic            ctl_dst_rd,
   input  logic            ctl_alu_imm,
   input  logic            ctl_branch,
   input  logic            ctl_mem_wr,
   input  logic            ctl_wb_mem,
   input  logic            ctl_jump,
   input  logic [2:0]      ctl_alu_op,
   output logic [5:0]      op_field,
   output logic [5:0]      fn_field,
   output logic [XLEN-1:0] dbg_pc,
   output logic [XLEN-1:0] dbg_instr,
   output logic [XLEN-1:0] dbg_alu_y,
   input  logic [RA_W-1:0] dbg_reg_sel,
   output logic [XLEN-1:0] dbg_reg_val
);
   logic [XLEN-1:0] pc, pc_next, instr, imm_ext;
   logic [XLEN-1:0] rd_a, rd_b, alu_b, alu_y, mem_rd, wb_data;
   logic [RA_W-1:0] wr_addr;
   logic            alu_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc <= '0;
      else        pc <= pc_next;
   end

   sc_word_mem #(.WORDS(IMEM_WORDS), .WRITABLE(1'b0), .INIT(IMEM_INIT)) u_imem (
      .clk(clk), .we(1'b0), .addr(pc), .wdata('0), .rdata(instr));

   assign wr_addr = ctl_dst_rd ? instr[15:11] : instr[20:16];
   assign imm_ext = sext_imm(instr[IMM_W-1:0]);

   sc_regfile u_rf (
      .clk(clk), .rst_n(rst_n), .we(ctl_reg_wr), .waddr(wr_addr), .wdata(wb_data),
      .raddr_a(instr[25:21]), .raddr_b(instr[20:16]), .raddr_d(dbg_reg_sel),
      .rdata_a(rd_a), .rdata_b(rd_b), .rdata_d(dbg_reg_val));

   assign alu_b = ctl_alu_imm ? imm_ext : rd_b;

   sc_alu u_alu (.a(rd_a), .b(alu_b), .op(ctl_alu_op), .y(alu_y), .zero(alu_zero));

   sc_word_mem #(.WORDS(DMEM_WORDS), .WRITABLE(1'b1), .INIT('0)) u_dmem (
      .clk(clk), .we(ctl_mem_wr), .addr(alu_y), .wdata(rd_b), .rdata(mem_rd));

   assign wb_data = ctl_wb_mem ? mem_rd : alu_y;

   sc_next_pc u_npc (
      .pc(pc), .imm_ext(imm_ext), .jidx(instr[JIDX_W-1:0]), .branch(ctl_branch),
      .zero(alu_zero), .jump(ctl_jump), .pc_next(pc_next));

   assign op_field  = instr[31:26];
   assign fn_field  = instr[5:0];
   assign dbg_pc    = pc;
   assign dbg_instr = instr;
   assign dbg_alu_y = alu_y;

   AST_PC_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_jump && !(ctl_branch && alu_zero)) |=> pc == $past(pc) + XLEN'(4)); // R7
   AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      pc[1:0] == 2'b00); // R8
   AST_JUMP_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_jump |=> pc[JIDX_W+1:2] == $past(instr[JIDX_W-1:0])); // R8
   AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_branch && alu_zero && !ctl_jump) |=>
         pc == $past(pc) + XLEN'(4) + {$past(imm_ext[XLEN-3:0]), 2'b00}); // R7
endmodule

// File: tb/sc_datapath_tb.sv
module sc_datapath_tb_top;
   localparam int NW = 32;

   function automatic logic [31:0] ri(input logic [5:0] op, input logic [4:0] rs,
                                      input logic [4:0] rt, input logic [15:0] imm);
      return {op, rs, rt, imm};
   endfunction
   function automatic logic [31:0] rr(input logic [4:0] rs, input logic [4:0] rt,
                                      input logic [4:0] rd, input logic [5:0] fn);
      return {6'd0, rs, rt, rd, 5'd0, fn};
   endfunction

   function automatic logic [NW*32-1:0] build_prog();
      logic [NW*32-1:0] p;
      p = '0;
      p[0*32 +: 32]  = ri(6'h08, 0, 1, 16'd5);
      p[1*32 +: 32]  = ri(6'h08, 0, 2, 16'hFFFD);
      p[2*32 +: 32]  = rr(1, 2, 3, 6'h20);
      p[3*32 +: 32]  = rr(1, 2, 4, 6'h22);
      p[4*32 +: 32]  = rr(1, 2, 5, 6'h24);
      p[5*32 +: 32]  = rr(2, 1, 6, 6'h2A);
      p[6*32 +: 32]  = ri(6'h2B, 1, 4, 16'd3);
      p[7*32 +: 32]  = ri(6'h23, 3, 7, 16'd6);
      p[8*32 +: 32]  = ri(6'h08, 0, 0, 16'd7);
      p[9*32 +: 32]  = ri(6'h04, 1, 2, 16'd5);
      p[10*32 +: 32] = ri(6'h04, 4, 7, 16'd2);
      p[11*32 +: 32] = {6'h02, 26'd16};
      p[13*32 +: 32] = ri(6'h04, 0, 0, 16'hFFFD);
      p[16*32 +: 32] = ri(6'h08, 0, 8, 16'd1);
      p[17*32 +: 32] = rr(1, 2, 9, 6'h25);
      p[18*32 +: 32] = rr(1, 1, 10, 6'h22);
      return p;
   endfunction

   localparam logic [NW*32-1:0] PROG = build_prog();

   // {reg_wr,dst_rd,alu_imm,branch,mem_wr,wb_mem,jump}, alu_op, next pc, reg, value
   localparam int NV = 16;
   localparam logic [78:0] VECS [NV] = '{
      {7'b1010000, 3'b010, 32'd4,  5'd1,  32'h00000005},  // R3 addi positive
      {7'b1010000, 3'b010, 32'd8,  5'd2,  32'hFFFFFFFD},  // R3 sign extension
      {7'b1100000, 3'b010, 32'd12, 5'd3,  32'h00000002},  // R4 add
      {7'b1100000, 3'b110, 32'd16, 5'd4,  32'h00000008},  // R4 sub
      {7'b1100000, 3'b000, 32'd20, 5'd5,  32'h00000005},  // R4 and
      {7'b1100000, 3'b111, 32'd24, 5'd6,  32'h00000001},  // R4 signed slt
      {7'b0010100, 3'b010, 32'd28, 5'd4,  32'h00000008},  // R5 store
      {7'b1010010, 3'b010, 32'd32, 5'd7,  32'h00000008},  // R5 load
      {7'b1010000, 3'b010, 32'd36, 5'd0,  32'h00000000},  // R11 write r0
      {7'b0001000, 3'b110, 32'd40, 5'd1,  32'h00000005},  // R7 not taken
      {7'b0001000, 3'b110, 32'd52, 5'd4,  32'h00000008},  // R7 forward
      {7'b0001000, 3'b110, 32'd44, 5'd0,  32'h00000000},  // R7 backward
      {7'b0000001, 3'b000, 32'd64, 5'd0,  32'h00000000},  // R8 jump
      {7'b0010000, 3'b010, 32'd68, 5'd8,  32'h00000000},  // R6 write disabled
      {7'b1100000, 3'b001, 32'd72, 5'd9,  32'hFFFFFFFD},  // R4 or
      {7'b1000000, 3'b110, 32'd76, 5'd1,  32'h00000000}   // R2 rt destination
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        c_rw = 0, c_dst = 0, c_imm = 0, c_br = 0, c_mw = 0, c_wbm = 0, c_j = 0;
   logic [2:0]  c_op = '0;
   logic [4:0]  dsel = '0;
   logic [5:0]  op_f, fn_f;
   logic [31:0] pc_o, instr_o, alu_o, rv_o;
   int          checks = 0;
   int          errors = 0;

   always #2 clk = ~clk;

   sc_datapath #(.IMEM_WORDS(NW), .DMEM_WORDS(32), .IMEM_INIT(PROG)) dut_i (
      .clk(clk), .rst_n(rst_n), .ctl_reg_wr(c_rw), .ctl_dst_rd(c_dst),
      .ctl_alu_imm(c_imm), .ctl_branch(c_br), .ctl_mem_wr(c_mw), .ctl_wb_mem(c_wbm),
      .ctl_jump(c_j), .ctl_alu_op(c_op), .op_field(op_f), .fn_field(fn_f),
      .dbg_pc(pc_o), .dbg_instr(instr_o), .dbg_alu_y(alu_o),
      .dbg_reg_sel(dsel), .dbg_reg_val(rv_o));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic read_reg(input logic [4:0] r, output logic [31:0] v);
      dsel = r;
      #0.5;
      v = rv_o;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R9 reset pc", pc_o, 32'd0);
      read_reg(5'd1, v);
      chk("R9 reset reg", v, 32'd0);
      chk("R10 opcode", {26'd0, op_f}, 32'h8);
      // ALU codes seen combinationally on addi r1,r0,5 while reset holds the PC
      c_imm = 1'b1;
      c_op = 3'b101; #0.5;
      chk("R4 orn", alu_o, 32'hFFFFFFFA);
      c_op = 3'b100; #0.5;
      chk("R4 andn", alu_o, 32'h0);
      c_op = 3'b011; #0.5;
      chk("R4 unused code", alu_o, 32'h0);
      c_imm = 1'b0; c_op = 3'b000;
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         {c_rw, c_dst, c_imm, c_br, c_mw, c_wbm, c_j} = VECS[i][78:72];
         c_op = VECS[i][71:69];
         @(negedge clk);
         chk($sformatf("R1 R7 vector %0d pc", i), pc_o, VECS[i][68:37]);
         read_reg(VECS[i][36:32], v);
         chk($sformatf("R1 vector %0d reg", i), v, VECS[i][31:0]);
         if (i == 1)
            chk("R10 funct", {26'd0, fn_f}, 32'h20);
      end
      {c_rw, c_dst, c_imm, c_br, c_mw, c_wbm, c_j} = '0;
      c_op = '0;
      read_reg(5'd10, v);
      chk("R2 rd untouched", v, 32'd0);
      read_reg(5'd3, v);
      chk("R1 r3 kept", v, 32'd2);

      @(negedge clk);
      rst_n = 1'b0;
      #0.5;
      chk("R9 midrun pc", pc_o, 32'd0);
      read_reg(5'd3, v);
      chk("R9 midrun reg", v, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule